// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a small successive-approximation ADC for a passive, field-powered sensor tag. A one-cycle start pulse opens a sampling window. During that window the sample control is held high, so the charge-redistribution DAC, which also does the sample-and-hold, stores the input charge on its array. When the sample control drops, the charge is frozen. The sequencer then runs a binary search over the code, one bit per clock, from the most significant bit down to the least significant. In each step it sets the bit under trial and lets the comparator decision either clear that bit or keep it.

The DAC array needs the inverted code. For this reason the switch word presented to it is the bitwise complement of the current trial code, and an all-zero switch word means full scale. When the last bit is decided, the finished code appears on the result port and the ready flag rises. Both hold until the next start. The whole conversion has to fit inside a fixed reply window of the air protocol. An elaboration-time check rejects any parameter set whose cycle count times the clock period would exceed that window.

Top module: `sar_conv_ctl`

## Requirements
- R1: Synchronous reset, whether applied while idle or in the middle of a conversion, leaves sample control low, ready low, the result at 0 and the switch word at all ones (trial code 0).
- R2: A start pulse seen while idle or ready raises sample control on the next clock edge. Sample control then stays high for exactly SAMPLE_CYCLES cycles (default 2) and drops afterwards.
- R3: In the first cycle after sample control falls, the trial code has only its most significant bit set. With the default width the switch word is then 0x7F.
- R4: In the decision cycle for bit k, the trial code holds the already decided higher bits with bit k set and all lower bits clear. A comparator input of 1 at the end of that cycle clears bit k, and 0 keeps it.
- R5: The switch word is always the bitwise complement of the trial code. The switch word is 0xFF while sampling and 0x00 for a full-scale code of 0xFF.
- R6: Ready rises exactly SAMPLE_CYCLES + WIDTH clock edges after the edge that accepted start. At that point the result equals the code found by the search, which for an ideal comparator is the input value.
- R7: While no start arrives, ready stays high and the result stays stable regardless of the comparator input. A start accepted while ready drops ready on the next edge.
- R8: A start that arrives while sampling or deciding is ignored. The conversion keeps its timing and its result.
- R9: With the default parameters, (SAMPLE_CYCLES + WIDTH) clock periods are below the reply window. Any parameter set that does not meet this fails elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a conversion |
| cmp_i | input | 1 | Comparator decision; 1 means the DAC output crossed the reference |
| sample_o | output | 1 | Sample/reset control for the DAC array |
| dac_sw_o | output | WIDTH | DAC switch word, complement of the trial code |
| result_o | output | WIDTH | Last finished conversion code |
| ready_o | output | 1 | High once the least significant bit has been decided |

## Verification
The bench builds the block with its default parameters: an 8-bit code, a two-cycle sampling window, the inverted switch polarity and a 1 µs target clock period against the 11.28 µs window. With two sampling cycles, the end of the sampling count is a genuine counter comparison, not a one-cycle special case. Because the code is 8 bits wide, an ideal comparator model can be checked directly on edge codes: 0x00, 0xFF, 0x80 and 0x7F force every bit decision both ways. A forced comparator level drives the search to the two extreme codes, and a start pulse is injected at chosen decision steps to show that it is ignored.

// File: rtl/sar_ctl_pkg.sv
package sar_ctl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SAMPLE = 2'd1,
      PH_DECIDE = 2'd2,
      PH_DONE   = 2'd3
   } sar_phase_e;

   function automatic int unsigned conv_cycles(input int unsigned width,
                                               input int unsigned samp);
      return width + samp;
   endfunction

endpackage

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
   import sar_ctl_pkg::*;
#(
   parameter int unsigned WIDTH         = 8,
   parameter int unsigned SAMPLE_CYCLES = 2,
   localparam int unsigned IDX_W        = $clog2(WIDTH),
   localparam int unsigned SCW          = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output logic             sample_o,
   output logic             ready_o,
   output logic             clear_o,
   output logic             seed_o,
   output logic             step_o,
   output logic             last_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [SCW-1:0]   SC_LAST = SCW'(SAMPLE_CYCLES - 1);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(WIDTH - 1);

   sar_phase_e       phase_q;
   logic [SCW-1:0]   scnt_q;
   logic [IDX_W-1:0] idx_q;
   logic             accept;

   assign accept = start && ((phase_q == PH_IDLE) || (phase_q == PH_DONE));

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         scnt_q  <= '0;
         idx_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE, PH_DONE: begin
               if (accept) begin
                  phase_q <= PH_SAMPLE;
                  scnt_q  <= '0;
               end
            end
            PH_SAMPLE: begin
               if (scnt_q == SC_LAST) begin
                  phase_q <= PH_DECIDE;
                  idx_q   <= IDX_TOP;
               end else begin
                  scnt_q <= scnt_q + 1'b1;
               end
            end
            PH_DECIDE: begin
               if (idx_q == '0) begin
                  phase_q <= PH_DONE;
               end else begin
                  idx_q <= idx_q - 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      sample_o = (phase_q == PH_SAMPLE);
      ready_o  = (phase_q == PH_DONE);
      clear_o  = accept;
      seed_o   = (phase_q == PH_SAMPLE) && (scnt_q == SC_LAST);
      step_o   = (phase_q == PH_DECIDE);
      last_o   = (phase_q == PH_DECIDE) && (idx_q == '0);
      idx_o    = idx_q;
   end

   AST_SAMPLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
      $rose(sample_o) |-> $past(start)); // R2

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_DECIDE) && start |=> (phase_q != PH_SAMPLE)); // R8

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IDX_W = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear_i,
   input  logic             seed_i,
   input  logic             step_i,
   input  logic             last_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             cmp_i,
   output logic [WIDTH-1:0] trial_o,
   output logic [WIDTH-1:0] result_o
);

   localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   logic [WIDTH-1:0] trial_q;
   logic [WIDTH-1:0] result_q;
   logic [WIDTH-1:0] trial_nxt;

   always_comb begin
      trial_nxt = trial_q;
      if (cmp_i) begin
         trial_nxt[idx_i] = 1'b0;
      end
      if (idx_i != '0) begin
         trial_nxt[idx_i - 1'b1] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         trial_q  <= '0;
         result_q <= '0;
      end else begin
         if (clear_i) begin
            trial_q <= '0;
         end else if (seed_i) begin
            trial_q <= MSB_ONLY;
         end else if (step_i) begin
            trial_q <= trial_nxt;
            if (last_i) begin
               result_q <= trial_nxt;
            end
         end
      end
   end

   assign trial_o  = trial_q;
   assign result_o = result_q;

   AST_ONE_BIT_PER_STEP: assert property (@(posedge clk) disable iff (rst)
      step_i |=> ($countones(trial_q) <= $countones($past(trial_q)) + 1)); // R4

endmodule

// File: rtl/sar_dac_drive.sv
module sar_dac_drive #(
   parameter int unsigned WIDTH           = 8,
   parameter bit          INVERT_SWITCHES = 1'b1
) (
   input  logic [WIDTH-1:0] trial_i,
   output logic [WIDTH-1:0] sw_o
);

   generate
      if (INVERT_SWITCHES) begin : g_inverted
         assign sw_o = ~trial_i;
      end else begin : g_direct
         assign sw_o = trial_i;
      end
   endgenerate

endmodule

// File: rtl/sar_conv_ctl.sv
module sar_conv_ctl
   import sar_ctl_pkg::*;
#(
   parameter int unsigned WIDTH           = 8,
   parameter int unsigned SAMPLE_CYCLES   = 2,
   parameter bit          INVERT_SWITCHES = 1'b1,
   parameter int unsigned CLK_PERIOD_NS   = 1000,
   parameter int unsigned REPLY_WINDOW_NS = 11280
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             cmp_i,
   output logic             sample_o,
   output logic [WIDTH-1:0] dac_sw_o,
   output logic [WIDTH-1:0] result_o,
   output logic             ready_o
);

   localparam int unsigned IDX_W    = $clog2(WIDTH);
   localparam int unsigned CONV_NS  = conv_cycles(WIDTH, SAMPLE_CYCLES) * CLK_PERIOD_NS;
   localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_conv_ctl: WIDTH must be at least 2");
      end
      if (SAMPLE_CYCLES < 1) begin : g_bad_sample
         $error("sar_conv_ctl: SAMPLE_CYCLES must be at least 1");
      end
      if (CONV_NS >= REPLY_WINDOW_NS) begin : g_bad_budget
         $error("sar_conv_ctl: conversion does not fit the reply window"); // R9
      end
   endgenerate

   logic             clear_w;
   logic             seed_w;
   logic             step_w;
   logic             last_w;
   logic [IDX_W-1:0] idx_w;
   logic [WIDTH-1:0] trial_w;

   sar_phase_seq #(
      .WIDTH         (WIDTH),
      .SAMPLE_CYCLES (SAMPLE_CYCLES)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .sample_o (sample_o),
      .ready_o  (ready_o),
      .clear_o  (clear_w),
      .seed_o   (seed_w),
      .step_o   (step_w),
      .last_o   (last_w),
      .idx_o    (idx_w)
   );

   sar_approx_reg #(
      .WIDTH (WIDTH)
   ) u_sar (
      .clk      (clk),
      .rst      (rst),
      .clear_i  (clear_w),
      .seed_i   (seed_w),
      .step_i   (step_w),
      .last_i   (last_w),
      .idx_i    (idx_w),
      .cmp_i    (cmp_i),
      .trial_o  (trial_w),
      .result_o (result_o)
   );

   sar_dac_drive #(
      .WIDTH           (WIDTH),
      .INVERT_SWITCHES (INVERT_SWITCHES)
   ) u_drv (
      .trial_i (trial_w),
      .sw_o    (dac_sw_o)
   );

   AST_MSB_SEED: assert property (@(posedge clk) disable iff (rst)
      $fell(sample_o) |-> (trial_w == MSB_ONLY)); // R3

   AST_RESULT_AT_READY: assert property (@(posedge clk) disable iff (rst)
      $rose(ready_o) |-> (result_o == trial_w)); // R6

   AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
      ready_o && !start |=> ready_o && $stable(result_o)); // R7

endmodule

// File: tb/tb_sar_conv_ctl.sv
module tb_sar_conv_ctl;

   localparam int W   = 8;
   localparam int S   = 2;
   localparam int PER = 1000;
   localparam int WIN = 11280;
   localparam int NV  = 8;
   localparam logic [W-1:0] VEC [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F,
                                          8'h01, 8'hA5, 8'h5A, 8'hFE};

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] vin = '0;
   logic         force_en = 1'b0;
   logic         force_val = 1'b0;
   logic         cmp;
   logic         sample;
   logic [W-1:0] dac_sw;
   logic [W-1:0] result;
   logic         ready;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   // ideal comparator: the DAC level corresponds to the trial code ~dac_sw
   assign cmp = force_en ? force_val : (logic'((~dac_sw) > vin));

   sar_conv_ctl #(
      .WIDTH         (W),
      .SAMPLE_CYCLES (S)
   ) dut (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .cmp_i    (cmp),
      .sample_o (sample),
      .dac_sw_o (dac_sw),
      .result_o (result),
      .ready_o  (ready)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic run_conv(input logic [W-1:0] v, input logic [W-1:0] exp,
                           input int glitch_k);
      logic [W-1:0] m;
      logic [W-1:0] tr;
      logic [W-1:0] msb;
      int           n;
      msb = W'(1) << (W - 1);
      n   = 0;
      @(negedge clk);
      vin   = v;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(ready == 1'b0, "R7 ready drop", 32'(ready), 32'd0);
      for (int i = 0; i < S; i++) begin
         chk(sample == 1'b1, "R2 sample high", 32'(sample), 32'd1);
         chk(dac_sw == {W{1'b1}}, "R5 sw while sampling", 32'(dac_sw), 32'hFF);
         n++;
         @(negedge clk);
      end
      chk(sample == 1'b0, "R2 sample low", 32'(sample), 32'd0);
      chk(dac_sw == ~msb, "R3 msb seed", 32'(dac_sw), 32'(~msb));
      for (int k = W - 1; k >= 0; k--) begin
         m  = (W'(1) << (k + 1)) - W'(1);
         tr = (exp & ~m) | (W'(1) << k);
         chk(dac_sw == ~tr, "R4 R5 trial step", 32'(dac_sw), 32'(~tr));
         chk(ready == 1'b0, "R6 not early", 32'(ready), 32'd0);
         if (k == glitch_k) start = 1'b1;
         n++;
         @(negedge clk);
         start = 1'b0;
      end
      chk(ready == 1'b1, "R6 ready", 32'(ready), 32'd1);
      chk(result == exp, "R6 result", 32'(result), 32'(exp));
      chk(n * PER < WIN, "R9 window", 32'(n * PER), 32'(WIN));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [W-1:0] keep;
      logic [W-1:0] rv;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sample == 1'b0, "R1 sample", 32'(sample), 32'd0);
      chk(ready == 1'b0, "R1 ready", 32'(ready), 32'd0);
      chk(result == '0, "R1 result", 32'(result), 32'd0);
      chk(dac_sw == {W{1'b1}}, "R1 sw", 32'(dac_sw), 32'hFF);
      rst = 1'b0;
      @(negedge clk);

      // table walk with an ideal comparator
      for (int i = 0; i < NV; i++) begin
         run_conv(VEC[i], VEC[i], -1);
      end
      for (int i = 0; i < 4; i++) begin
         rv = W'($urandom);
         run_conv(rv, rv, -1);
      end

      // R7 hold while idle with a toggling comparator
      keep = result;
      force_en = 1'b1;
      for (int i = 0; i < 6; i++) begin
         force_val = i[0];
         @(negedge clk);
         chk(ready == 1'b1, "R7 ready hold", 32'(ready), 32'd1);
         chk(result == keep, "R7 result hold", 32'(result), 32'(keep));
      end
      force_en = 1'b0;

      // R8 start during conversion ignored
      run_conv(8'h3C, 8'h3C, 4);
      run_conv(8'hC3, 8'hC3, 0);
      @(negedge clk);
      chk(ready == 1'b1, "R8 no restart", 32'(ready), 32'd1);
      chk(sample == 1'b0, "R8 no sample", 32'(sample), 32'd0);

      // R4 forced comparator levels, R5 full scale
      force_en  = 1'b1;
      force_val = 1'b1;
      run_conv(8'h55, 8'h00, -1);
      force_val = 1'b0;
      run_conv(8'h55, 8'hFF, -1);
      chk(dac_sw == '0, "R5 full scale sw", 32'(dac_sw), 32'd0);
      force_en = 1'b0;

      // R1 reset in the middle of a conversion
      @(negedge clk);
      vin   = 8'h96;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(sample == 1'b0, "R1 mid sample", 32'(sample), 32'd0);
      chk(ready == 1'b0, "R1 mid ready", 32'(ready), 32'd0);
      chk(result == '0, "R1 mid result", 32'(result), 32'd0);
      chk(dac_sw == {W{1'b1}}, "R1 mid sw", 32'(dac_sw), 32'hFF);
      run_conv(8'h96, 8'h96, -1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule